// File: doc/BRIEF.md
# Direction-Gated ADC Trigger Generator

This block produces two A/D converter start-request pulses, A and B, for a PWM timer that counts up and then down. Each request starts from a compare match between the timer count and an active compare register. The match raises a request only when the enable for the present count direction is set. A request can also be tied to the interrupt-skipping status of two sources: the channel-3 compare-A interrupt and the channel-4 overflow/underflow interrupt. When it is tied, the request fires only in the period whose interrupt is not skipped.

A 16-bit control register holds the per-direction enables, the four skip-link bits and a two-bit transfer-mode field. The transfer-mode field chooses when the two buffer compare values are copied into the active compare registers: at the crest, at the trough, at both, or never. The counter, the skip counters and the converter are outside the block. The count, the direction, the mode, the skip status and the crest/trough events all arrive as inputs.

Each trigger is handled by a small two-state machine. The states are ARMED (a match may fire) and SPENT (this direction has already matched). The transitions are *fire* (ARMED to SPENT on a match), *hold* (SPENT stays SPENT while the direction is unchanged) and *rearm* (SPENT back to ARMED, or straight to firing again, once the direction differs from the one recorded at the last match).

Top module: `adc_trig_gen`

## Requirements
- R1: After reset the control register reads 0x0000, both active compare registers are 0 and neither request is asserted.
- R2: A write with `reg_full`=1 stores bits 15:14 and 7:0. Bits 13:8 always read as zero. The field positions are: bit 7 A up-enable, bit 6 A down-enable, bit 5 B up-enable, bit 4 B down-enable, bit 3 A link to channel-3 skipping, bit 2 A link to channel-4 skipping, bit 1 B link to channel-3 skipping, bit 0 B link to channel-4 skipping, bits 15:14 transfer mode.
- R3: A write with `reg_full`=0 (byte access) leaves the register unchanged.
- R4: While counting up (`tmr_down`=0), a cycle in which the count equals a trigger's active compare value gives a one-cycle request on the next clock edge, provided that trigger's up-enable is set. With the up-enable clear there is no request.
- R5: While counting down, a request needs both the trigger's down-enable and `cpwm_mode`=1. The up-enable has no effect while counting down.
- R6: A trigger issues at most one request per count direction, even if the match lasts several cycles. A change of direction rearms it.
- R7: If a trigger has a link bit set whose source has skipping disabled, that trigger issues no requests.
- R8: If a trigger has link bits set and all linked sources have skipping enabled, a request passes only when at least one linked source reports its non-skipped period (`skip*_hit`=1).
- R9: Transfer mode 00 never copies, 01 copies at a crest pulse, 10 copies at a trough pulse and 11 copies at both. The buffer values appear on `cmp_a`/`cmp_b` one clock after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_full | input | 1 | 1 = full 16-bit access, 0 = byte access (ignored) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Control register read value |
| tmr_cnt | input | CNT_W | Timer count |
| tmr_down | input | 1 | 1 = counting down |
| cpwm_mode | input | 1 | Complementary PWM mode active |
| skip3_en | input | 1 | Channel-3 compare-A skipping enabled |
| skip4_en | input | 1 | Channel-4 overflow/underflow skipping enabled |
| skip3_hit | input | 1 | Channel-3 skip counter at its programmed count this period |
| skip4_hit | input | 1 | Channel-4 skip counter at its programmed count this period |
| crest | input | 1 | One-cycle pulse where up-count turns to down-count |
| trough | input | 1 | One-cycle pulse at the bottom of the count |
| buf_a | input | CNT_W | Buffer compare value A |
| buf_b | input | CNT_W | Buffer compare value B |
| cmp_a | output | CNT_W | Active compare value A |
| cmp_b | output | CNT_W | Active compare value B |
| req_a | output | 1 | Start request A (one-cycle pulse) |
| req_b | output | 1 | Start request B (one-cycle pulse) |

## Verification
The assertions assume the following about the inputs:
- `crest` and `trough` are single-cycle events.
- The skip enable and skip hit levels, and the direction, are stable for the cycle in which a match is sampled.
- `$past` values after reset reflect real driven inputs.

The stimulus meets these assumptions:
- Every input changes only on the falling clock edge.
- Direction is flipped only while the count sits away from both compare values, except in the deliberate rearm test.
- Each event pulse is held for exactly one cycle.

// File: rtl/adctg_pkg.sv
package adctg_pkg;

    typedef enum logic [1:0] {
        XFER_NONE   = 2'b00,
        XFER_CREST  = 2'b01,
        XFER_TROUGH = 2'b10,
        XFER_BOTH   = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic a_up;
        logic a_dn;
        logic b_up;
        logic b_dn;
        logic a_lk3;
        logic a_lk4;
        logic b_lk3;
        logic b_lk4;
    } ctl_t;

    typedef enum logic {
        CH_ARMED = 1'b0,
        CH_SPENT = 1'b1
    } ch_state_e;

    localparam int unsigned NUM_TRIG = 2;

endpackage

// File: rtl/adctg_ctrl_reg.sv
module adctg_ctrl_reg
    import adctg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic        full_i,
    input  logic [15:0] wdata_i,
    output ctl_t        ctl_o,
    output logic [15:0] rdata_o
);
    ctl_t ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_i && full_i) begin
            ctl_q <= {wdata_i[15:14], wdata_i[7:0]};
        end
    end

    assign ctl_o   = ctl_q;
    assign rdata_o = {ctl_q.mode, 6'b0, ctl_q[7:0]};

    // R3: byte-wide writes leave the register untouched
    a_r3_byte_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !full_i) |=> $stable(rdata_o));

endmodule

// File: rtl/adctg_xfer.sv
module adctg_xfer
    import adctg_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xfer_mode_e       mode_i,
    input  logic             crest_i,
    input  logic             trough_i,
    input  logic [CNT_W-1:0] buf_a_i,
    input  logic [CNT_W-1:0] buf_b_i,
    output logic [CNT_W-1:0] cmp_a_o,
    output logic [CNT_W-1:0] cmp_b_o
);
    logic do_copy;

    always_comb begin
        unique case (mode_i)
            XFER_NONE:   do_copy = 1'b0;
            XFER_CREST:  do_copy = crest_i;
            XFER_TROUGH: do_copy = trough_i;
            XFER_BOTH:   do_copy = crest_i | trough_i;
            default:     do_copy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_a_o <= '0;
            cmp_b_o <= '0;
        end else if (do_copy) begin
            cmp_a_o <= buf_a_i;
            cmp_b_o <= buf_b_i;
        end
    end

    // R9: crest copy in modes 01 and 11
    a_r9_crest_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (crest_i && mode_i[0]) |=> (cmp_a_o == $past(buf_a_i)) && (cmp_b_o == $past(buf_b_i)));

    // R9: nothing is copied in mode 00
    a_r9_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == XFER_NONE) |=> $stable(cmp_a_o) && $stable(cmp_b_o));

endmodule

// File: rtl/adctg_trig_ch.sv
module adctg_trig_ch
    import adctg_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             dir_down_i,
    input  logic             cpwm_i,
    input  logic             en_up_i,
    input  logic             en_dn_i,
    input  logic             lk3_i,
    input  logic             lk4_i,
    input  logic             se3_i,
    input  logic             se4_i,
    input  logic             hit3_i,
    input  logic             hit4_i,
    output logic             req_o
);
    ch_state_e state_q, state_d;
    logic      spent_dir_q, spent_dir_d;
    logic      match, armed_now, fire, dir_ok, blocked, link_ok, pass;

    assign match     = (cnt_i == cmp_i);
    assign armed_now = (state_q == CH_ARMED) || (dir_down_i != spent_dir_q);
    assign fire      = armed_now && match;

    assign dir_ok  = dir_down_i ? (en_dn_i && cpwm_i) : en_up_i;
    assign blocked = (lk3_i && !se3_i) || (lk4_i && !se4_i);
    assign link_ok = !(lk3_i || lk4_i) || (lk3_i && hit3_i) || (lk4_i && hit4_i);
    assign pass    = dir_ok && !blocked && link_ok;

    always_comb begin
        state_d     = state_q;
        spent_dir_d = spent_dir_q;
        unique case (state_q)
            CH_ARMED: begin
                if (fire) begin
                    state_d     = CH_SPENT;
                    spent_dir_d = dir_down_i;
                end
            end
            CH_SPENT: begin
                if (fire) begin
                    spent_dir_d = dir_down_i;
                end else if (armed_now) begin
                    state_d = CH_ARMED;
                end
            end
            default: state_d = CH_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= CH_ARMED;
            spent_dir_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            spent_dir_q <= spent_dir_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_o <= 1'b0;
        end else begin
            req_o <= fire && pass;
        end
    end

    // R6: no second pulse while the direction holds
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $stable(dir_down_i)) |=> !req_o);

    // R5: down-count requests only in complementary PWM mode
    a_r5_down_needs_cpwm: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (!$past(dir_down_i) || $past(cpwm_i)));

    // R7: a link to a source without skipping blocks the trigger
    a_r7_link_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !$past((lk3_i && !se3_i) || (lk4_i && !se4_i)));

    // R4: a request follows a match of the count against the compare value
    a_r4_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(cnt_i == cmp_i));

endmodule

// File: rtl/adc_trig_gen.sv
module adc_trig_gen
    import adctg_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_full,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic             tmr_down,
    input  logic             cpwm_mode,
    input  logic             skip3_en,
    input  logic             skip4_en,
    input  logic             skip3_hit,
    input  logic             skip4_hit,
    input  logic             crest,
    input  logic             trough,
    input  logic [CNT_W-1:0] buf_a,
    input  logic [CNT_W-1:0] buf_b,
    output logic [CNT_W-1:0] cmp_a,
    output logic [CNT_W-1:0] cmp_b,
    output logic             req_a,
    output logic             req_b
);
    ctl_t ctl;
    logic [NUM_TRIG-1:0] en_up, en_dn, lk3, lk4, req;
    logic [CNT_W-1:0]    cmp_arr [NUM_TRIG];

    adctg_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .full_i  (reg_full),
        .wdata_i (reg_wdata),
        .ctl_o   (ctl),
        .rdata_o (reg_rdata)
    );

    adctg_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (ctl.mode),
        .crest_i  (crest),
        .trough_i (trough),
        .buf_a_i  (buf_a),
        .buf_b_i  (buf_b),
        .cmp_a_o  (cmp_a),
        .cmp_b_o  (cmp_b)
    );

    assign en_up = {ctl.b_up,  ctl.a_up};
    assign en_dn = {ctl.b_dn,  ctl.a_dn};
    assign lk3   = {ctl.b_lk3, ctl.a_lk3};
    assign lk4   = {ctl.b_lk4, ctl.a_lk4};
    assign cmp_arr[0] = cmp_a;
    assign cmp_arr[1] = cmp_b;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
        adctg_trig_ch #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_i      (tmr_cnt),
            .cmp_i      (cmp_arr[g]),
            .dir_down_i (tmr_down),
            .cpwm_i     (cpwm_mode),
            .en_up_i    (en_up[g]),
            .en_dn_i    (en_dn[g]),
            .lk3_i      (lk3[g]),
            .lk4_i      (lk4[g]),
            .se3_i      (skip3_en),
            .se4_i      (skip4_en),
            .hit3_i     (skip3_hit),
            .hit4_i     (skip4_hit),
            .req_o      (req[g])
        );
    end

    assign req_a = req[0];
    assign req_b = req[1];

    // R2: reserved bits never read back as one
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_full) |=> (reg_rdata[13:8] == 6'b0) && (reg_rdata[7:0] == $past(reg_wdata[7:0])));

endmodule

// File: tb/adc_trig_gen_tb.sv
module adc_trig_gen_tb_top;
    localparam int unsigned W  = 16;
    localparam logic [W-1:0] CA = 16'd100;
    localparam logic [W-1:0] CB = 16'd200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 0, reg_full = 0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [W-1:0] tmr_cnt = '0;
    logic tmr_down = 0, cpwm_mode = 0;
    logic skip3_en = 0, skip4_en = 0, skip3_hit = 0, skip4_hit = 0;
    logic crest = 0, trough = 0;
    logic [W-1:0] buf_a = '0, buf_b = '0, cmp_a, cmp_b;
    logic req_a, req_b;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    adc_trig_gen #(.CNT_W(W)) dut_i (.*);

    // [23:8] ctrl, [7] cpwm, [6] down, [5] se3, [4] se4, [3] hit3, [2] hit4, [1] exp A, [0] exp B
    localparam logic [23:0] VEC [12] = '{
        {16'h00A0, 8'b0_0_0000_11},  // R4 both up-enabled
        {16'h0000, 8'b0_0_0000_00},  // R4 no enables
        {16'h0080, 8'b0_0_0000_10},  // R4 only A
        {16'h0050, 8'b1_1_0000_11},  // R5 down enabled, cpwm on
        {16'h0050, 8'b0_1_0000_00},  // R5 cpwm off
        {16'h00A0, 8'b1_1_0000_00},  // R5 up enables ignored when down
        {16'h00A8, 8'b0_0_0000_01},  // R7 A linked, skipping off
        {16'h00A8, 8'b0_0_1000_01},  // R8 skipped period
        {16'h00A8, 8'b0_0_1010_11},  // R8 non-skipped period
        {16'h00AF, 8'b0_0_1101_11},  // R8 either link suffices
        {16'h00AF, 8'b0_0_1010_00},  // R7 channel-4 skipping off
        {16'h00A1, 8'b0_0_0100_10}   // R8 B linked, skipped period
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1, 2:  return "R4";
            3, 4, 5:  return "R5";
            6, 10:    return "R7";
            default:  return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(logic [15:0] v, logic full);
        @(negedge clk);
        reg_wr = 1; reg_full = full; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0; reg_full = 0;
    endtask

    task automatic rearm(logic d);
        @(negedge clk); tmr_cnt = '0; tmr_down = ~d;
        @(negedge clk); tmr_down = d;
    endtask

    task automatic pulse_event(logic is_crest);
        @(negedge clk);
        crest = is_crest; trough = ~is_crest;
        @(negedge clk);
        crest = 0; trough = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int pulses;
        repeat (3) @(negedge clk);
        check("R1 rdata", reg_rdata, 0);
        check("R1 req", {req_a, req_b}, 0);
        check("R1 cmp", {cmp_a, cmp_b}, 0);
        rst_n = 1;

        // R2 full write, reserved bits read zero
        write_reg(16'hFFFF, 1);
        check("R2 readback", reg_rdata, 32'hC0FF);
        // R3 byte write ignored
        write_reg(16'h1234, 0);
        check("R3 byte write", reg_rdata, 32'hC0FF);

        // load compare values with mode 11 at a crest (R9)
        buf_a = CA; buf_b = CB;
        pulse_event(1'b1);
        check("R9 both at crest", {cmp_a, cmp_b}, {CA, CB});

        // vector table
        for (int i = 0; i < 12; i++) begin
            write_reg(VEC[i][23:8], 1);
            cpwm_mode = VEC[i][7];
            skip3_en = VEC[i][5]; skip4_en = VEC[i][4];
            skip3_hit = VEC[i][3]; skip4_hit = VEC[i][2];
            rearm(VEC[i][6]);
            @(negedge clk); tmr_cnt = CA;
            @(negedge clk);
            check(vec_tag(i), req_a, VEC[i][1]);
            tmr_cnt = CB;
            @(negedge clk);
            check(vec_tag(i), req_b, VEC[i][0]);
            tmr_cnt = '0;
        end
        skip3_en = 0; skip4_en = 0; skip3_hit = 0; skip4_hit = 0;

        // R6 long match gives one pulse per direction
        write_reg(16'h00C0, 1);
        cpwm_mode = 1;
        rearm(1'b0);
        @(negedge clk); tmr_cnt = CA;
        pulses = 0;
        repeat (3) begin @(negedge clk); pulses += req_a; end
        check("R6 up single", pulses, 1);
        tmr_down = 1;
        pulses = 0;
        repeat (3) begin @(negedge clk); pulses += req_a; end
        check("R6 rearm on turn", pulses, 1);
        tmr_cnt = '0;

        // R9 transfer modes
        buf_a = 16'd11; buf_b = 16'd22;
        write_reg(16'h0000, 1);
        pulse_event(1'b1);
        check("R9 mode 00", {cmp_a, cmp_b}, {CA, CB});
        write_reg(16'h4000, 1);
        pulse_event(1'b0);
        check("R9 mode 01 trough", {cmp_a, cmp_b}, {CA, CB});
        pulse_event(1'b1);
        check("R9 mode 01 crest", {cmp_a, cmp_b}, {16'd11, 16'd22});
        buf_a = 16'd33; buf_b = 16'd44;
        write_reg(16'h8000, 1);
        pulse_event(1'b1);
        check("R9 mode 10 crest", {cmp_a, cmp_b}, {16'd11, 16'd22});
        pulse_event(1'b0);
        check("R9 mode 10 trough", {cmp_a, cmp_b}, {16'd33, 16'd44});
        buf_a = CA; buf_b = CB;
        write_reg(16'hC000, 1);
        pulse_event(1'b0);
        check("R9 mode 11 trough", {cmp_a, cmp_b}, {CA, CB});

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule